// File: doc/BRIEF.md
# Boot-ROM and RAM Memory Unit with Address and Data Registers

This block is the memory side of a small accumulator-style processor. It has a 12-bit address register and a 16-bit data register. The lowest 64 addresses hold a fixed boot program, and every address above them is read/write RAM. The processor drives the block with four strobes: one loads the address register, one copies the addressed word into the data register, one writes the shared bus value into RAM, and one places the data register on the output bus.

Input and output data paths are separate ports, so the block has no bidirectional pin. A read takes three steps in order: load the address, fetch into the data register, then drive the bus. A write takes two steps: load the address, then store. A store aimed at the boot-program region is dropped, and the block raises a flag for one cycle. A parameter picks the idle state of the output bus: all zeros for a multiplexed bus, or high impedance for a shared bus.

Top module: `mem_unit`

## Requirements
- R1: On a rising edge with load_mar high, the address register takes bus_in[11:0]; bits 15:12 of bus_in are discarded. With load_mar low it holds its value.
- R2: An address selects RAM when any of bits 11..6 is 1. Otherwise it selects the boot-program word at offset address[5:0].
- R3: Boot-program word k (k = 0..63) has bits 15:8 equal to k and bits 7:0 equal to the bitwise inverse of k in 8 bits.
- R4: On a rising edge with read_ram high, the data register captures the word at the current address register. read_ram alone never drives bus_out.
- R5: While send_mbr is high, bus_out equals the data register in the same cycle. While send_mbr is low, bus_out is all zeros in the default variant, or high impedance when TRISTATE_OUT=1.
- R6: On a rising edge with write_ram high and an address register value of 64 or more, the RAM word at that address takes bus_in. A later read returns that value.
- R7: A write_ram at an address below 64 changes no stored word. A later read of that address still returns the boot-program word.
- R8: wr_blocked is high for exactly the one cycle after an edge that saw write_ram with an address below 64. It is low at all other times, including after an accepted write.
- R9: After reset the address register is 0, the data register is 0 and wr_blocked is 0.
- R10: When read_ram and write_ram share an edge, the data register captures the word as it was before the write.
- R11: The data register holds its value on every edge where read_ram is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Data and address from the processor bus |
| load_mar | input | 1 | Load address register from bus_in |
| read_ram | input | 1 | Copy addressed word into data register |
| write_ram | input | 1 | Store bus_in at the addressed RAM word |
| send_mbr | input | 1 | Drive data register onto bus_out |
| bus_out | output | 16 | Data register output when enabled |
| wr_blocked | output | 1 | One-cycle flag for a dropped write to the boot region |

## Verification
The address register, the data register and wr_blocked all change on the rising edge that samples their strobe. Their effect therefore shows one edge later. bus_out follows send_mbr in the same cycle with no register between them. The bench changes inputs on the falling edge and updates its behavioural model on the rising edge. It compares bus_out and wr_blocked one time unit after every rising edge, so each value is checked in the cycle it is due and held until the next input change.

// File: rtl/mem_unit_pkg.sv
package mem_unit_pkg;
   typedef struct packed {
      logic addr_load;
      logic fetch;
      logic store;
      logic drive;
   } strobe_t;

   function automatic int boot_word(input int k, input int half);
      int lo_mask;
      lo_mask = (1 << half) - 1;
      return ((k & lo_mask) << half) | (~k & lo_mask);
   endfunction
endpackage

// File: rtl/mem_addr_decode.sv
module mem_addr_decode #(
   parameter int ADDR_W  = 12,
   parameter int PROM_AW = 6
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic               sel_ram,
   output logic [PROM_AW-1:0] prom_off
);
   assign sel_ram  = |addr[ADDR_W-1:PROM_AW];
   assign prom_off = addr[PROM_AW-1:0];
endmodule

// File: rtl/mem_prom.sv
module mem_prom #(
   parameter int PROM_AW = 6,
   parameter int DATA_W  = 16
) (
   input  logic [PROM_AW-1:0] offset,
   output logic [DATA_W-1:0]  data
);
   localparam int WORDS = 1 << PROM_AW;
   localparam int HALF  = DATA_W / 2;

   logic [DATA_W-1:0] table_w [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      localparam int VAL = mem_unit_pkg::boot_word(i, HALF);
      assign table_w[i] = DATA_W'(VAL);
   end

   assign data = table_w[offset];
endmodule

// File: rtl/mem_ram_store.sv
module mem_ram_store #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/mem_unit.sv
module mem_unit #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter int PROM_AW      = 6,
   parameter bit TRISTATE_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_in,
   input  logic              load_mar,
   input  logic              read_ram,
   input  logic              write_ram,
   input  logic              send_mbr,
   output logic [DATA_W-1:0] bus_out,
   output logic              wr_blocked
);
   import mem_unit_pkg::*;

   localparam int HALF = DATA_W / 2;

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("mem_unit: ADDR_W must not exceed DATA_W");
   end
   if (PROM_AW >= ADDR_W) begin : g_bad_prom
      $error("mem_unit: PROM_AW must be below ADDR_W");
   end
   if ((DATA_W % 2) != 0 || PROM_AW > HALF) begin : g_bad_data
      $error("mem_unit: DATA_W must be even and hold the boot offset in its upper half");
   end

   strobe_t           st;
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] mbr_q;
   logic              sel_ram;
   logic [PROM_AW-1:0] prom_off;
   logic [DATA_W-1:0] prom_data;
   logic [DATA_W-1:0] ram_data;
   logic [DATA_W-1:0] rd_word;

   assign st = '{addr_load: load_mar, fetch: read_ram, store: write_ram, drive: send_mbr};

   mem_addr_decode #(.ADDR_W(ADDR_W), .PROM_AW(PROM_AW)) u_dec (
      .addr     (mar_q),
      .sel_ram  (sel_ram),
      .prom_off (prom_off)
   );

   mem_prom #(.PROM_AW(PROM_AW), .DATA_W(DATA_W)) u_prom (
      .offset (prom_off),
      .data   (prom_data)
   );

   mem_ram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (st.store & sel_ram),
      .addr  (mar_q),
      .wdata (bus_in),
      .rdata (ram_data)
   );

   assign rd_word = sel_ram ? ram_data : prom_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q      <= '0;
         mbr_q      <= '0;
         wr_blocked <= 1'b0;
      end else begin
         if (st.addr_load) mar_q <= bus_in[ADDR_W-1:0];
         if (st.fetch)     mbr_q <= rd_word;
         wr_blocked <= st.store & ~sel_ram;
      end
   end

   if (TRISTATE_OUT) begin : g_out_z
      assign bus_out = st.drive ? mbr_q : {DATA_W{1'bz}};
   end else begin : g_out_mux
      assign bus_out = st.drive ? mbr_q : '0;
   end
endmodule

// File: rtl/mem_unit_chk.sv
module mem_unit_chk #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter int PROM_AW      = 6,
   parameter bit TRISTATE_OUT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] bus_in,
   input logic              load_mar,
   input logic              read_ram,
   input logic              write_ram,
   input logic              send_mbr,
   input logic [DATA_W-1:0] bus_out,
   input logic              wr_blocked,
   input logic [ADDR_W-1:0] mar,
   input logic [DATA_W-1:0] mbr
);
   localparam int HALF = DATA_W / 2;

   function automatic logic [DATA_W-1:0] exp_boot(input logic [ADDR_W-1:0] a);
      return DATA_W'(mem_unit_pkg::boot_word(int'(a[PROM_AW-1:0]), HALF));
   endfunction

   p_mar_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load_mar |=> mar == $past(bus_in[ADDR_W-1:0]));

   p_mar_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !load_mar |=> $stable(mar));

   p_boot_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (read_ram && !(|mar[ADDR_W-1:PROM_AW])) |=> mbr == exp_boot($past(mar)));

   p_send_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      send_mbr |-> bus_out == mbr);

   if (!TRISTATE_OUT) begin : g_idle
      p_bus_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !send_mbr |-> bus_out == '0);
   end

   p_blocked_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (write_ram && !(|mar[ADDR_W-1:PROM_AW])) |=> wr_blocked);

   p_blocked_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(write_ram && !(|mar[ADDR_W-1:PROM_AW])) |=> !wr_blocked);

   p_mbr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !read_ram |=> $stable(mbr));
endmodule

bind mem_unit mem_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROM_AW(PROM_AW), .TRISTATE_OUT(TRISTATE_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_mar(load_mar),
   .read_ram(read_ram), .write_ram(write_ram), .send_mbr(send_mbr),
   .bus_out(bus_out), .wr_blocked(wr_blocked), .mar(mar_q), .mbr(mbr_q)
);

// File: tb/mem_unit_test.sv
module mem_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_in = '0;
   logic        load_mar = 1'b0, read_ram = 1'b0, write_ram = 1'b0, send_mbr = 1'b0;
   logic [15:0] bus_out;
   logic        wr_blocked;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int          m_mar = 0;
   logic [15:0] m_mbr = '0;
   bit          m_known = 1'b1;
   bit          m_blk = 1'b0;
   logic [15:0] m_ram [int];

   always #5 clk = ~clk;

   mem_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_mar(load_mar),
      .read_ram(read_ram), .write_ram(write_ram), .send_mbr(send_mbr),
      .bus_out(bus_out), .wr_blocked(wr_blocked)
   );

   function automatic logic [15:0] boot_ref(input int k);
      return 16'(((k & 255) << 8) | ((~k) & 255));
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic lm, input logic rr, input logic wr, input logic sm,
                       input logic [15:0] din, input string tag);
      int old;
      @(negedge clk);
      load_mar = lm; read_ram = rr; write_ram = wr; send_mbr = sm; bus_in = din;
      @(posedge clk);
      old = m_mar;
      if (rr) begin
         if (old < 64) begin
            m_mbr = boot_ref(old); m_known = 1'b1;
         end else if (m_ram.exists(old)) begin
            m_mbr = m_ram[old]; m_known = 1'b1;
         end else begin
            m_known = 1'b0;
         end
      end
      if (wr && old >= 64) m_ram[old] = din;
      m_blk = wr && (old < 64);
      if (lm) m_mar = int'(din[11:0]);
      #1;
      if (!sm) chk({tag, " bus idle R5"}, bus_out, 16'h0);
      else if (m_known) chk(tag, bus_out, m_mbr);
      chk({tag, " flag R8"}, {15'b0, wr_blocked}, {15'b0, m_blk});
   endtask

   task automatic rd(input logic [15:0] a, input string tag);
      step(1, 0, 0, 0, a, "R1 load");
      step(0, 1, 0, 0, 16'hFFFF, "R4 fetch");
      step(0, 0, 0, 1, 16'h0, tag);
   endtask

   task automatic wrt(input logic [15:0] a, input logic [15:0] d, input string tag);
      step(1, 0, 0, 0, a, "R1 load");
      step(0, 0, 1, 0, d, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset bus", bus_out, 16'h0);
      chk("R9 reset flag", {15'b0, wr_blocked}, 16'h0);
      @(negedge clk); send_mbr = 1'b1;
      #1 chk("R9 reset mbr", bus_out, 16'h0);
      @(negedge clk); send_mbr = 1'b0; rst_n = 1'b1;

      step(0, 1, 0, 1, 16'h0, "R9 mar zero R3");
      for (int k = 0; k < 64; k += 7) rd(16'(k), "R3 boot word");
      rd(16'd63, "R2 boot top");
      rd(16'hF03F, "R1 upper bus bits ignored R3");

      wrt(16'd64, 16'hA5A5, "R6 write 64");
      wrt(16'hFFF, 16'h1234, "R6 write top");
      wrt(16'h840, 16'hBEEF, "R6 write A11");
      wrt(16'h100, 16'h0F0F, "R6 write mid");
      rd(16'd64, "R6 R2 read 64");
      rd(16'hFFF, "R6 read top");
      rd(16'h840, "R6 read A11");
      rd(16'h100, "R6 read mid");

      wrt(16'd0, 16'hDEAD, "R7 blocked 0");
      step(0, 0, 0, 0, 16'h0, "R8 flag one cycle");
      wrt(16'd63, 16'hDEAD, "R7 blocked 63");
      wrt(16'd5, 16'h5555, "R7 blocked 5");
      rd(16'd0, "R7 boot 0 intact");
      rd(16'd63, "R7 boot 63 intact");
      rd(16'd5, "R7 boot 5 intact");

      step(1, 0, 0, 0, 16'h200, "R1 load");
      step(0, 0, 1, 0, 16'h7777, "R6 first");
      step(0, 1, 1, 0, 16'h9999, "R10 read+write");
      step(0, 0, 0, 1, 16'h0, "R10 old word");
      step(0, 1, 0, 1, 16'h0, "R10 new word R4");

      for (int i = 0; i < 4; i++) step(i[0], 0, 0, 1, 16'(64 + i), "R11 hold");
      step(0, 1, 0, 0, 16'h0, "R4 no drive");
      step(0, 0, 0, 1, 16'h0, "R11 after fetch");

      for (int i = 0; i < 8; i++) wrt(16'(12'h400 + i * 37), 16'(i * 16'h1357 + 3), "R6 sweep");
      for (int i = 0; i < 8; i++) rd(16'(12'h400 + i * 37), "R6 sweep read");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule